// File: doc/BRIEF.md
# Ping-Pong LIFO Sample Reverser

This block produces a time-reversed copy of a sample stream for the reverse delay path of a symmetric decimating FIR filter. It holds two last-in-first-out stacks. At any moment one stack is the receiving stack, filled from the tail of the forward path. The other is the sending stack, drained in reverse order into the reverse path. The caller pushes and pops in the same cycle: the push goes to the receiving stack and the pop is taken from the sending stack.

A transfer control input is registered, and the block then detects its falling edge. Each detected falling edge exchanges the two roles. The stack that becomes the receiving stack starts again from empty. The stack that becomes the sending stack keeps everything it was filled with, so the block that was just captured is read back in reverse order. A hold input freezes both stacks and the popped-data register. The role exchange still takes place while hold is high.

Top module: `lifo_pingpong`

## Requirements
- R1: On a rising edge where push_i=1 and hold_i=0, push_data_i is stored on top of the receiving stack. On a rising edge where pop_i=1 and hold_i=0, pop_data_o takes the most recently stored entry of the sending stack, and that entry is removed. Entries therefore come out in the reverse of the order they went in.
- R2: xfer_i is sampled on every rising edge. When it is sampled 1 at edge k-1 and 0 at edge k, the roles exchange at edge k+1. At that edge rx_sel_o toggles, where 0 means stack 0 is receiving and 1 means stack 1 is receiving.
- R3: No exchange occurs while xfer_i is sampled 0 on consecutive edges, while it is sampled 1 on consecutive edges, or on a rising 0-to-1 sample.
- R4: While hold_i=1 at an edge, no push or pop happens and rx_count_o, tx_count_o and pop_data_o keep their values, except that a role exchange due at that edge still occurs.
- R5: A pop from a sending stack that holds 0 entries drives pop_data_o to 0.
- R6: Each stack holds at most DEPTH entries (16 by default). A push to a full receiving stack is discarded: the stack contents and count are unchanged, and drop_o is 1 for the cycle after that edge. Otherwise drop_o is 0.
- R7: At an exchange edge, the newly receiving stack is emptied. A push on that same edge becomes its only entry. The newly sending stack keeps its fill count, and a pop on that same edge is taken from it.
- R8: While rst_ni=0, both stacks are empty, rx_sel_o=0, pop_data_o=0 and drop_o=0. The registered transfer control reads 0.
- R9: pop_data_o changes only on an edge with pop_i=1 and hold_i=0. Otherwise it holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push push_data_i onto the receiving stack |
| push_data_i | input | DATA_W | Sample from the forward path |
| pop_i | input | 1 | Pop one sample from the sending stack |
| hold_i | input | 1 | Freeze pushes, pops and popped data |
| xfer_i | input | 1 | Transfer control; its registered falling edge swaps the roles |
| pop_data_o | output | DATA_W | Last popped sample, or 0 if the pop found the stack empty |
| drop_o | output | 1 | A push was discarded on the previous edge because the stack was full |
| rx_sel_o | output | 1 | Index of the receiving stack |
| rx_count_o | output | CW | Entry count of the receiving stack |
| tx_count_o | output | CW | Entry count of the sending stack |

## Verification
Pushes, pops, drops and count changes are all visible on the outputs one edge after the cycle that drives them. A role exchange shows up one edge later than that, because the falling edge of xfer_i is seen through its register first. The bench applies each stimulus half a clock before an edge and compares every output 1 ns after that edge. It compares against a behavioural model that is advanced once per edge and keeps its own two-sample history of xfer_i. Stimulus sweeps fill levels from 0 to DEPTH+1, so every exchange, empty-pop, full-drop and hold case lands on a known edge.

// File: rtl/lifo_pp_pkg.sv
package lifo_pp_pkg;
  parameter int unsigned SAMPLE_W   = 10;
  parameter int unsigned LIFO_DEPTH = 16;

  typedef enum logic {
    ROLE_RX0 = 1'b0,
    ROLE_RX1 = 1'b1
  } role_e;
endpackage

// File: rtl/lifo_stack.sv
module lifo_stack #(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] top_o,
  output logic [CW-1:0]     count_o,
  output logic              full_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [CW-1:0]     cnt_q;
  logic [AW-1:0]     wr_idx, top_idx;
  logic              empty_w;

  assign empty_w = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign wr_idx  = clear_i ? '0 : AW'(cnt_q);
  assign top_idx = AW'(cnt_q - 1'b1);
  assign top_o   = empty_w ? '0 : mem_q[top_idx];
  assign count_o = cnt_q;

  // clear and push on the same edge: the push becomes the first entry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= push_i ? CW'(1) : '0;
    end else if (push_i && !full_o) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (pop_i && !empty_w) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && (clear_i || !full_o)) mem_q[wr_idx] <= data_i;
  end
endmodule

// File: rtl/xfer_fall_det.sv
module xfer_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic fall_o
);
  logic lvl_q, lvl_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      lvl_d <= 1'b0;
    end else begin
      lvl_q <= lvl_i;
      lvl_d <= lvl_q;
    end
  end

  assign fall_o = lvl_d & ~lvl_q;
endmodule

// File: rtl/lifo_role_ctrl.sv
module lifo_role_ctrl
  import lifo_pp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  swap_i,
  output role_e rx_q_o,
  output role_e rx_next_o
);
  role_e rx_q;

  assign rx_next_o = swap_i ? role_e'(~rx_q) : rx_q;
  assign rx_q_o    = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_q <= ROLE_RX0;
    else         rx_q <= rx_next_o;
  end
endmodule

// File: rtl/lifo_pingpong.sv
module lifo_pingpong
  import lifo_pp_pkg::*;
#(
  parameter int unsigned DATA_W = SAMPLE_W,
  parameter int unsigned DEPTH  = LIFO_DEPTH,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic              hold_i,
  input  logic              xfer_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              drop_o,
  output logic              rx_sel_o,
  output logic [CW-1:0]     rx_count_o,
  output logic [CW-1:0]     tx_count_o
);
  logic              swap_w, push_en, pop_en;
  role_e             rx_q, rx_next;
  logic [DATA_W-1:0] top_w [2];
  logic [CW-1:0]     cnt_w [2];
  logic              full_w [2];
  logic [DATA_W-1:0] pop_data_q;
  logic              drop_q;

  assign push_en = push_i & ~hold_i;
  assign pop_en  = pop_i & ~hold_i;

  xfer_fall_det u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (xfer_i),
    .fall_o (swap_w)
  );

  lifo_role_ctrl u_role (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .swap_i    (swap_w),
    .rx_q_o    (rx_q),
    .rx_next_o (rx_next)
  );

  for (genvar g = 0; g < 2; g++) begin : g_stk
    logic is_rx;
    assign is_rx = (rx_next == role_e'(g));

    lifo_stack #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
    ) u_stk (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (swap_w & is_rx),
      .push_i  (push_en & is_rx),
      .pop_i   (pop_en & ~is_rx),
      .data_i  (push_data_i),
      .top_o   (top_w[g]),
      .count_o (cnt_w[g]),
      .full_o  (full_w[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pop_data_q <= '0;
      drop_q     <= 1'b0;
    end else begin
      if (pop_en) pop_data_q <= top_w[~rx_next];
      drop_q <= push_en & ~swap_w & full_w[rx_next];
    end
  end

  assign pop_data_o = pop_data_q;
  assign drop_o     = drop_q;
  assign rx_sel_o   = rx_q;
  assign rx_count_o = cnt_w[rx_q];
  assign tx_count_o = cnt_w[~rx_q];
endmodule

// File: rtl/lifo_pingpong_chk.sv
module lifo_pingpong_chk #(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned CW     = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              push_i,
  input logic              pop_i,
  input logic              hold_i,
  input logic              swap_w,
  input logic [DATA_W-1:0] pop_data_o,
  input logic              drop_o,
  input logic              rx_sel_o,
  input logic [CW-1:0]     rx_count_o,
  input logic [CW-1:0]     tx_count_o
);
  AST_SWAP_TOGGLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_w |=> (rx_sel_o != $past(rx_sel_o))); // R2

  AST_NO_SPURIOUS_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !swap_w |=> $stable(rx_sel_o)); // R3

  AST_HOLD_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !swap_w) |=> ($stable(rx_count_o) && $stable(tx_count_o) && $stable(pop_data_o))); // R4

  AST_EMPTY_POP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !hold_i && !swap_w && tx_count_o == '0) |=> (pop_data_o == '0)); // R5

  AST_DROP_ONLY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> (rx_count_o == CW'(DEPTH))); // R6

  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_count_o <= CW'(DEPTH)) && (tx_count_o <= CW'(DEPTH))); // R6

  AST_SWAP_EMPTIES_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap_w && !(push_i && !hold_i)) |=> (rx_count_o == '0)); // R7

  AST_SWAP_KEEPS_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap_w && !(pop_i && !hold_i)) |=> (tx_count_o == $past(rx_count_o))); // R7

  AST_POPDATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop_i && !hold_i) |=> $stable(pop_data_o)); // R9
endmodule

bind lifo_pingpong lifo_pingpong_chk #(
  .DATA_W (DATA_W),
  .DEPTH  (DEPTH),
  .CW     (CW)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .push_i     (push_i),
  .pop_i      (pop_i),
  .hold_i     (hold_i),
  .swap_w     (swap_w),
  .pop_data_o (pop_data_o),
  .drop_o     (drop_o),
  .rx_sel_o   (rx_sel_o),
  .rx_count_o (rx_count_o),
  .tx_count_o (tx_count_o)
);

// File: tb/lifo_pingpong_tb_top.sv
`timescale 1ns/1ps
module lifo_pingpong_tb_top;
  localparam int DW = 10;
  localparam int D  = 16;
  localparam int CW = $clog2(D + 1);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          push_i = 1'b0, pop_i = 1'b0, hold_i = 1'b0, xfer_i = 1'b0;
  logic [DW-1:0] push_data_i = '0;
  logic [DW-1:0] pop_data_o;
  logic          drop_o, rx_sel_o;
  logic [CW-1:0] rx_count_o, tx_count_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // behavioural model
  int m_stk [2][D];
  int m_cnt [2];
  int m_rx, m_pd, m_drop;
  bit m_xq, m_xd;

  always #2.5 clk_i = ~clk_i;

  lifo_pingpong #(.DATA_W(DW), .DEPTH(D)) dut_i (
    .clk_i, .rst_ni, .push_i, .push_data_i, .pop_i, .hold_i, .xfer_i,
    .pop_data_o, .drop_o, .rx_sel_o, .rx_count_o, .tx_count_o
  );

  task automatic chk(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "pop_data_o", int'(pop_data_o), m_pd);
    chk(tag, "drop_o", int'(drop_o), m_drop);
    chk(tag, "rx_sel_o", int'(rx_sel_o), m_rx);
    chk(tag, "rx_count_o", int'(rx_count_o), m_cnt[m_rx]);
    chk(tag, "tx_count_o", int'(tx_count_o), m_cnt[1 - m_rx]);
  endtask

  task automatic model_reset();
    m_cnt[0] = 0; m_cnt[1] = 0;
    m_rx = 0; m_pd = 0; m_drop = 0; m_xq = 0; m_xd = 0;
  endtask

  // one clock: drive at negedge, update model at posedge, compare 1 ns later
  task automatic step(string tag, bit psh, bit pp, bit hld, bit xf, int d);
    bit sw;
    @(negedge clk_i);
    push_i = psh; pop_i = pp; hold_i = hld; xfer_i = xf; push_data_i = DW'(d);
    @(posedge clk_i);
    sw = m_xd && !m_xq;
    m_xd = m_xq; m_xq = xf;
    if (sw) begin
      m_rx = 1 - m_rx;
      m_cnt[m_rx] = 0;
    end
    m_drop = 0;
    if (psh && !hld) begin
      if (m_cnt[m_rx] < D) begin
        m_stk[m_rx][m_cnt[m_rx]] = d;
        m_cnt[m_rx]++;
      end else m_drop = 1;
    end
    if (pp && !hld) begin
      if (m_cnt[1 - m_rx] > 0) begin
        m_cnt[1 - m_rx]--;
        m_pd = m_stk[1 - m_rx][m_cnt[1 - m_rx]];
      end else m_pd = 0;
    end
    #1;
    compare(tag);
  endtask

  function automatic int smp(int n, int i);
    return (n * 37 + i * 11 + 5) & 10'h3ff;
  endfunction

  initial begin
    #(5.0 * 50000);
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    #1;
    compare("R8");
    repeat (3) @(negedge clk_i);
    compare("R8");
    rst_ni = 1'b1;
    step("R8", 0, 0, 0, 0, 0);

    // R1 R5 R6 R7: fill levels 0..D+1, swap, drain past empty while refilling
    for (int n = 0; n <= D + 1; n++) begin
      for (int i = 0; i < n; i++) step("R6", 1, 1, 0, 0, smp(n, i));
      step("R2", 0, 0, 0, 1, 0);
      step("R2", 0, 0, 0, 0, 0);
      step("R7", 1, 1, 0, 0, smp(n, 99));
      for (int i = 0; i < n + 2; i++) step("R1", (i % 3) != 0, 1, 0, 0, smp(n + 1, i));
      step("R5", 0, 1, 0, 0, 0);
    end

    // R3: xfer held high, held low, rising only
    step("R3", 1, 0, 0, 1, 17);
    for (int i = 0; i < 6; i++) step("R3", 1, 0, 0, 1, i + 40);
    for (int i = 0; i < 6; i++) step("R3", 1, 1, 0, 0, i + 50);
    for (int i = 0; i < 6; i++) step("R3", 0, 1, 0, 0, 0);

    // R4 R9: hold patterns, swap under hold
    for (int i = 0; i < 40; i++)
      step((i % 3 == 0) ? "R4" : "R9", 1, (i % 2) == 0, (i % 3) == 0, (i % 11) == 4, smp(7, i));
    step("R4", 1, 1, 1, 1, 300);
    step("R4", 1, 1, 1, 0, 301);
    step("R4", 1, 1, 1, 0, 302);
    for (int i = 0; i < 20; i++) step("R9", i < 4, (i % 4) == 1, 0, 0, smp(9, i));

    // R7: push and pop on exchange edge, back-to-back exchanges
    for (int i = 0; i < 5; i++) step("R7", 1, 0, 0, 0, 500 + i);
    step("R7", 1, 1, 0, 1, 510);
    step("R7", 1, 1, 0, 0, 511);
    step("R7", 1, 1, 0, 1, 512);
    step("R7", 1, 1, 0, 0, 513);
    for (int i = 0; i < 8; i++) step("R7", 0, 1, 0, 0, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule